// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side protocol engine of a serial flash memory. It watches a chip-select, a serial clock and a serial data input, all sampled on the system clock, and assembles each transaction from these bits. A transaction is an opcode byte, then any address, dummy and data bytes. At the end of each transaction the block decides whether the command runs. For every accepted command it raises a one-cycle strobe. The strobe carries the opcode, the 24-bit command address and the count of data bytes received.

Program and status-write data bytes are passed on to the memory side as they arrive, each with its index. The strobe at the end tells the memory side whether to commit the staged bytes. For reads, the block asks the memory side for bytes and shifts them out MSB first. It can also return the status byte, an identification word or a signature byte. The block holds the write-enable latch. A busy input from the array stops commands from reaching the array while an internal cycle runs.

Top module: `flash_cmd_front`

## Requirements
- R1: Bits are sampled MSB first on rising serial-clock edges while cs_n is low. The opcodes are: 06h set write enable, 04h clear write enable, 05h read status, 01h write status, 03h read, 0Bh fast read, 02h program, D8h sector erase, C7h full erase, B9h power-down, 9Fh read identification, ABh wake with signature.
- R2: Opcodes 06h, 04h, B9h, C7h, D8h, 01h and 02h execute only when cs_n rises after a whole number of bytes with a legal byte count. The legal counts are: 1 byte for 06h, 04h, B9h and C7h; 4 bytes for D8h; 2 bytes for 01h; 5 or more bytes for 02h. Any other ending produces no strobe and leaves wel unchanged.
- R3: An accepted command produces a one-cycle pulse on cmd_valid in the clock after cs_n is first seen high. The pulse carries cmd_op, cmd_addr and cmd_len. cmd_addr holds the three bytes after the opcode, MSB first, for 03h, 0Bh, 02h and D8h, and zero for all other opcodes.
- R4: Opcodes 02h, D8h, C7h and 01h are accepted only while wel is 1, and accepting one of them clears wel. 06h sets wel and 04h clears it. wel changes only in a cycle where cmd_valid is high.
- R5: Data bytes of 02h (those after the address) and the single data byte of 01h each produce a wr_valid pulse with wr_byte and wr_idx, with wr_idx counting from 0. For 02h, cmd_len counts at most PAGE_BYTES bytes. Bytes past that limit are neither streamed nor counted.
- R6: For 03h, the byte at rd_addr is driven on sdo MSB first once the third address byte is in. Its first bit is valid before the next serial-clock rise, and sdo advances one bit on each rise. The address increments per byte, and rd_req pulses once per byte fetched. 0Bh behaves the same but inserts one dummy byte before the data.
- R7: 05h returns the status byte, with bit 1 = wel, bit 0 = busy and the other bits 0. The status is sampled again for each byte and repeats for as long as the clock runs.
- R8: 9Fh returns the bytes of ID_WORD, most significant first, and starts again from the first after the fourth. ABh takes three dummy bytes and then returns SIG_BYTE repeatedly.
- R9: Read-type commands (03h, 0Bh, 05h, 9Fh, ABh) may end after any bit of the output phase and are then accepted. Ending one before its header is complete produces no strobe.
- R10: If busy is high when an opcode completes, every opcode other than 05h is ignored until cs_n rises. An ignored opcode produces no strobe and no rd_req, keeps sdo_oe low and leaves wel unchanged.
- R11: An unknown opcode is ignored until cs_n rises: no strobe and sdo_oe stays low.
- R12: sdo_oe is high only during an output phase with cs_n low, and drops in the cycle cs_n is high. After reset, sdo_oe, cmd_valid and wel are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sck | input | 1 | Serial clock level, sampled by clk |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| busy | input | 1 | Array internal cycle in progress |
| wel | output | 1 | Write-enable latch |
| rd_req | output | 1 | Pulse: byte at rd_addr consumed this cycle |
| rd_addr | output | 24 | Array read address |
| rd_data | input | 8 | Array byte at rd_addr, same cycle |
| wr_valid | output | 1 | Pulse: streamed data byte |
| wr_idx | output | IDX_W | Index of streamed byte |
| wr_byte | output | 8 | Streamed data byte |
| cmd_valid | output | 1 | Pulse: accepted command |
| cmd_op | output | 8 | Accepted opcode |
| cmd_addr | output | 24 | Command address |
| cmd_len | output | LEN_W | Data bytes received |

## Verification
The bench keeps the default PAGE_BYTES of 256. At that size a program command of more than 256 data bytes fits in a few thousand clocks, so the length cap and the cut-off of the stream can both be checked. ID_WORD and SIG_BYTE are set to distinct non-default values, so the identification wrap after the fourth byte and the repeated signature can each be told apart from zero or stale data. The array model returns a byte computed from the address, so reads that cross a 64K boundary show whether the address carry is correct.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    localparam logic [7:0] OPC_WEN    = 8'h06;
    localparam logic [7:0] OPC_WDIS   = 8'h04;
    localparam logic [7:0] OPC_RSTAT  = 8'h05;
    localparam logic [7:0] OPC_WSTAT  = 8'h01;
    localparam logic [7:0] OPC_RD     = 8'h03;
    localparam logic [7:0] OPC_FRD    = 8'h0B;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_SERASE = 8'hD8;
    localparam logic [7:0] OPC_CERASE = 8'hC7;
    localparam logic [7:0] OPC_SLEEP  = 8'hB9;
    localparam logic [7:0] OPC_RID    = 8'h9F;
    localparam logic [7:0] OPC_WAKE   = 8'hAB;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OP, ST_IN, ST_OUT, ST_DROP
    } fe_state_e;

    typedef struct packed {
        logic       known;
        logic       rd;
        logic       needs_wel;
        logic       has_addr;
        logic [2:0] hdr;
        logic [2:0] exact;
        logic       at_least;
    } op_info_t;

    function automatic op_info_t decode_op(input logic [7:0] opc);
        op_info_t i;
        i = '0;
        i.known = 1'b1;
        case (opc)
            OPC_WEN, OPC_WDIS, OPC_SLEEP: i.exact = 3'd1;
            OPC_CERASE: begin i.needs_wel = 1'b1; i.exact = 3'd1; end
            OPC_SERASE: begin i.needs_wel = 1'b1; i.has_addr = 1'b1; i.exact = 3'd4; end
            OPC_PROG:   begin i.needs_wel = 1'b1; i.has_addr = 1'b1; i.exact = 3'd5; i.at_least = 1'b1; end
            OPC_WSTAT:  begin i.needs_wel = 1'b1; i.exact = 3'd2; end
            OPC_RD:     begin i.rd = 1'b1; i.has_addr = 1'b1; i.hdr = 3'd4; end
            OPC_FRD:    begin i.rd = 1'b1; i.has_addr = 1'b1; i.hdr = 3'd5; end
            OPC_RSTAT, OPC_RID: begin i.rd = 1'b1; i.hdr = 3'd1; end
            OPC_WAKE:   begin i.rd = 1'b1; i.hdr = 3'd4; end
            default:    i.known = 1'b0;
        endcase
        return i;
    endfunction

endpackage

// File: rtl/fe_shifter.sv
module fe_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       sdi,
    output logic       sck_rise,
    output logic       cs_end,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic [2:0] bitc,
    output logic [2:0] bcnt
);
    logic       sck_q;
    logic       cs_q;
    logic [6:0] shin;

    assign sck_rise  = !cs_n && sck && !sck_q;
    assign cs_end    = cs_n && !cs_q;
    assign byte_done = sck_rise && (bitc == 3'd7);
    assign byte_val  = {shin, sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
            shin  <= '0;
            bitc  <= '0;
            bcnt  <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                bitc <= '0;
                bcnt <= '0;
            end else if (sck_rise) begin
                shin <= {shin[5:0], sdi};
                bitc <= bitc + 3'd1;
                if (byte_done && bcnt != 3'd7) bcnt <= bcnt + 3'd1;
            end
        end
    end

    // R1
    bcnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> (bcnt >= $past(bcnt)));

endmodule

// File: rtl/fe_txreg.sv
module fe_txreg (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       shift,
    input  logic [7:0] din,
    output logic       sdo
);
    logic [7:0] sh;

    assign sdo = sh[7];

    always_ff @(posedge clk) begin
        if (rst)        sh <= '0;
        else if (load)  sh <= din;
        else if (shift) sh <= {sh[6:0], 1'b0};
    end

    // R6
    load_shift_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(load && shift));

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
    import flash_fe_pkg::*;
#(
    parameter int          PAGE_BYTES = 256,
    parameter logic [31:0] ID_WORD    = 32'h1F_2A_30_41,
    parameter logic [7:0]  SIG_BYTE   = 8'h11,
    localparam int         IDX_W      = $clog2(PAGE_BYTES),
    localparam int         LEN_W      = $clog2(PAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             sdi,
    output logic             sdo,
    output logic             sdo_oe,
    input  logic             busy,
    output logic             wel,
    output logic             rd_req,
    output logic [23:0]      rd_addr,
    input  logic [7:0]       rd_data,
    output logic             wr_valid,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_byte,
    output logic             cmd_valid,
    output logic [7:0]       cmd_op,
    output logic [23:0]      cmd_addr,
    output logic [LEN_W-1:0] cmd_len
);
    logic       sck_rise, cs_end, byte_done;
    logic [7:0] byte_val;
    logic [2:0] bitc, bcnt;

    fe_shifter u_shift (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .sck_rise(sck_rise), .cs_end(cs_end), .byte_done(byte_done),
        .byte_val(byte_val), .bitc(bitc), .bcnt(bcnt)
    );

    fe_state_e        st;
    logic [7:0]       op;
    logic [23:0]      addr, rd_ptr, addr_cur;
    logic [LEN_W-1:0] dcnt;
    logic [1:0]       id_idx;
    logic [7:0]       op_cur, tx_din, id_byte, status;
    op_info_t         info, opc_info;
    logic             op_phase, blocked, hdr_fin, load, shift, arr_rd;
    logic             cnt_ok, accept;

    assign info     = decode_op(op);
    assign opc_info = decode_op(byte_val);
    assign op_phase = (st == ST_IDLE) || (st == ST_OP);
    assign op_cur   = op_phase ? byte_val : op;
    assign blocked  = !opc_info.known || (busy && byte_val != OPC_RSTAT);

    assign hdr_fin = byte_done &&
        ((op_phase && !blocked && opc_info.rd && opc_info.hdr == 3'd1) ||
         (st == ST_IN && info.rd && ({1'b0, bcnt} + 4'd1 == {1'b0, info.hdr})));
    assign load   = hdr_fin || (st == ST_OUT && byte_done);
    assign shift  = (st == ST_OUT) && sck_rise && !byte_done;
    assign arr_rd = (op_cur == OPC_RD) || (op_cur == OPC_FRD);

    assign addr_cur = (st == ST_IN && byte_done && info.has_addr && bcnt == 3'd3)
                      ? {addr[15:0], byte_val} : addr;
    assign rd_addr  = (st == ST_OUT) ? rd_ptr : addr_cur;
    assign rd_req   = load && arr_rd;
    assign status   = {6'b0, wel, busy};
    assign sdo_oe   = (st == ST_OUT) && !cs_n;

    always_comb begin
        case (id_idx)
            2'd0:    id_byte = ID_WORD[31:24];
            2'd1:    id_byte = ID_WORD[23:16];
            2'd2:    id_byte = ID_WORD[15:8];
            default: id_byte = ID_WORD[7:0];
        endcase
        case (op_cur)
            OPC_RD, OPC_FRD: tx_din = rd_data;
            OPC_RSTAT:       tx_din = status;
            OPC_RID:         tx_din = id_byte;
            default:         tx_din = SIG_BYTE;
        endcase
    end

    fe_txreg u_tx (
        .clk(clk), .rst(rst), .load(load), .shift(shift), .din(tx_din), .sdo(sdo)
    );

    assign cnt_ok = info.at_least ? (bcnt >= info.exact) : (bcnt == info.exact);
    assign accept = (st == ST_OUT) ||
                    (st == ST_IN && !info.rd && bitc == 3'd0 && cnt_ok &&
                     (!info.needs_wel || wel));

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;  op <= '0;  addr <= '0;  rd_ptr <= '0;
            dcnt <= '0;  id_idx <= '0;  wel <= 1'b0;
            cmd_valid <= 1'b0;  cmd_op <= '0;  cmd_addr <= '0;  cmd_len <= '0;
            wr_valid <= 1'b0;  wr_idx <= '0;  wr_byte <= '0;
        end else begin
            cmd_valid <= 1'b0;
            wr_valid  <= 1'b0;
            if (cs_n) begin
                st <= ST_IDLE;  addr <= '0;  dcnt <= '0;  id_idx <= '0;
                if (cs_end && accept) begin
                    cmd_valid <= 1'b1;
                    cmd_op    <= op;
                    cmd_addr  <= addr;
                    cmd_len   <= dcnt;
                    if (op == OPC_WEN)                       wel <= 1'b1;
                    else if (op == OPC_WDIS || info.needs_wel) wel <= 1'b0;
                end
            end else begin
                if (st == ST_IDLE) st <= ST_OP;
                if (byte_done) begin
                    case (st)
                        ST_IDLE, ST_OP: begin
                            op <= byte_val;
                            if (blocked)                                  st <= ST_DROP;
                            else if (opc_info.rd && opc_info.hdr == 3'd1) st <= ST_OUT;
                            else                                          st <= ST_IN;
                        end
                        ST_IN: begin
                            if (info.has_addr && bcnt <= 3'd3) addr <= {addr[15:0], byte_val};
                            if (hdr_fin) st <= ST_OUT;
                            if ((op == OPC_PROG && bcnt >= 3'd4 && dcnt < LEN_W'(PAGE_BYTES)) ||
                                (op == OPC_WSTAT && bcnt == 3'd1)) begin
                                wr_valid <= 1'b1;
                                wr_byte  <= byte_val;
                                wr_idx   <= dcnt[IDX_W-1:0];
                                dcnt     <= dcnt + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (load) begin
                    if (arr_rd)          rd_ptr <= rd_addr + 24'd1;
                    if (op_cur == OPC_RID) id_idx <= id_idx + 2'd1;
                end
            end
        end
    end

    logic cmd_needs_wel;
    assign cmd_needs_wel = decode_op(cmd_op).needs_wel;

    // R3
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);
    // R3
    cmd_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(cs_n));
    // R4
    wel_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wel) |-> cmd_valid);
    // R4
    wel_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_needs_wel) |-> $past(wel));

endmodule

// File: tb/tb_flash_cmd_front.sv
module tb_flash_cmd_front;
    localparam int CLK_P = 10;
    localparam int PAGE  = 256;
    localparam logic [31:0] IDW = 32'hC2_20_13_7A;
    localparam logic [7:0]  SIG = 8'h5D;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, busy = 1'b0;
    logic sdo, sdo_oe, wel, rd_req, wr_valid, cmd_valid;
    logic [23:0] rd_addr, cmd_addr;
    logic [7:0]  rd_data, wr_byte, cmd_op;
    logic [7:0]  wr_idx;
    logic [8:0]  cmd_len;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction
    assign rd_data = mem_f(rd_addr);

    flash_cmd_front #(.PAGE_BYTES(PAGE), .ID_WORD(IDW), .SIG_BYTE(SIG)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo),
        .sdo_oe(sdo_oe), .busy(busy), .wel(wel), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid),
        .wr_idx(wr_idx), .wr_byte(wr_byte), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len)
    );

    int n_chk = 0, n_bad = 0, n_rdreq = 0;
    logic [47:0] exp_cmd[$];
    logic [15:0] exp_wr[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [7:0] o, input logic [23:0] a, input logic [15:0] l);
        exp_cmd.push_back({o, a, l});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_req) n_rdreq++;
            if (cmd_valid) begin
                if (exp_cmd.size() == 0) chk(0, "R3 unexpected strobe", {cmd_op, cmd_addr, 7'd0, cmd_len}, 0);
                else begin
                    logic [47:0] e;
                    e = exp_cmd.pop_front();
                    chk(e == {cmd_op, cmd_addr, 7'd0, cmd_len}, "R3 strobe fields", {cmd_op, cmd_addr, 7'd0, cmd_len}, e);
                end
            end
            if (wr_valid) begin
                if (exp_wr.size() == 0) chk(0, "R5 unexpected data byte", {wr_idx, wr_byte}, 0);
                else begin
                    logic [15:0] w;
                    w = exp_wr.pop_front();
                    chk(w == {wr_idx, wr_byte}, "R5 data byte", {wr_idx, wr_byte}, w);
                end
            end
        end
    end

    task automatic cs_go;
        cs_n = 1'b0; repeat (2) @(negedge clk);
    endtask
    task automatic cs_stop;
        sck = 1'b0; cs_n = 1'b1; repeat (4) @(negedge clk);
    endtask
    task automatic tx_bit(input logic b, output logic r);
        sdi = b; repeat (2) @(negedge clk);
        r = sdo; sck = 1'b1; repeat (2) @(negedge clk); sck = 1'b0;
    endtask
    task automatic tx_byte(input logic [7:0] v, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic bb;
            tx_bit(v[i], bb);
            r[i] = bb;
        end
    endtask
    task automatic cmd1(input logic [7:0] o);
        logic [7:0] d;
        cs_go; tx_byte(o, d); cs_stop;
    endtask
    task automatic rdsr(input logic [7:0] exp, input string tag);
        logic [7:0] d;
        push_cmd(8'h05, 24'h0, 16'd0);
        cs_go; tx_byte(8'h05, d); tx_byte(8'h00, d);
        chk(d == exp, tag, d, exp);
        tx_byte(8'h00, d);
        chk(d == exp, tag, d, exp);
        cs_stop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic b;
        int r0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sdo_oe == 0, "R12 reset oe", sdo_oe, 0);
        chk(wel == 0, "R12 reset wel", wel, 0);
        chk(cmd_valid == 0, "R12 reset strobe", cmd_valid, 0);

        rdsr(8'h00, "R7 status idle");
        // R4 set and clear latch
        push_cmd(8'h06, 0, 0); cmd1(8'h06);
        rdsr(8'h02, "R7 status wel");
        push_cmd(8'h04, 0, 0); cmd1(8'h04);
        rdsr(8'h00, "R4 clear latch");

        // R1 R5 program with latch
        push_cmd(8'h06, 0, 0); cmd1(8'h06);
        push_cmd(8'h02, 24'h012345, 3);
        exp_wr.push_back({8'd0, 8'hAA}); exp_wr.push_back({8'd1, 8'h55}); exp_wr.push_back({8'd2, 8'h0F});
        cs_go; tx_byte(8'h02, d); tx_byte(8'h01, d); tx_byte(8'h23, d); tx_byte(8'h45, d);
        tx_byte(8'hAA, d); tx_byte(8'h55, d); tx_byte(8'h0F, d); cs_stop;
        rdsr(8'h00, "R4 latch cleared by program");

        // R4 program without latch: streamed, not accepted
        exp_wr.push_back({8'd0, 8'h77});
        cs_go; tx_byte(8'h02, d); tx_byte(8'h00, d); tx_byte(8'h00, d); tx_byte(8'h10, d); tx_byte(8'h77, d); cs_stop;
        chk(exp_cmd.size() == 0, "R4 no strobe without latch", exp_cmd.size(), 0);

        // R2 misaligned erase rejected
        push_cmd(8'h06, 0, 0); cmd1(8'h06);
        cs_go; tx_byte(8'hD8, d); tx_byte(8'h04, d); tx_byte(8'h00, d); tx_byte(8'h00, d);
        for (int i = 0; i < 3; i++) tx_bit(1'b0, b);
        cs_stop;
        rdsr(8'h02, "R2 misaligned leaves latch");
        push_cmd(8'hD8, 24'h040000, 0);
        cs_go; tx_byte(8'hD8, d); tx_byte(8'h04, d); tx_byte(8'h00, d); tx_byte(8'h00, d); cs_stop;
        rdsr(8'h00, "R2 aligned erase accepted");
        cs_go; tx_byte(8'h06, d); tx_byte(8'h00, d); cs_stop;
        rdsr(8'h00, "R2 wrong count rejected");

        // R6 R9 read across 64K boundary, ended mid-byte
        r0 = n_rdreq;
        push_cmd(8'h03, 24'h00FFFE, 0);
        cs_go; tx_byte(8'h03, d); tx_byte(8'h00, d); tx_byte(8'hFF, d); tx_byte(8'hFE, d);
        chk(sdo_oe == 1, "R12 oe in output phase", sdo_oe, 1);
        tx_byte(8'h00, d); chk(d == mem_f(24'h00FFFE), "R6 read byte0", d, mem_f(24'h00FFFE));
        tx_byte(8'h00, d); chk(d == mem_f(24'h00FFFF), "R6 read byte1", d, mem_f(24'h00FFFF));
        tx_byte(8'h00, d); chk(d == mem_f(24'h010000), "R6 read byte2", d, mem_f(24'h010000));
        for (int i = 0; i < 5; i++) tx_bit(1'b0, b);
        cs_stop;
        chk(sdo_oe == 0, "R12 oe off after cs", sdo_oe, 0);
        chk(n_rdreq - r0 == 4, "R6 rd_req count", n_rdreq - r0, 4);

        // R6 fast read
        push_cmd(8'h0B, 24'h000100, 0);
        cs_go; tx_byte(8'h0B, d); tx_byte(8'h00, d); tx_byte(8'h01, d); tx_byte(8'h00, d); tx_byte(8'h00, d);
        tx_byte(8'h00, d); chk(d == mem_f(24'h000100), "R6 fast byte0", d, mem_f(24'h000100));
        tx_byte(8'h00, d); chk(d == mem_f(24'h000101), "R6 fast byte1", d, mem_f(24'h000101));
        cs_stop;

        // R8 identification wraps, signature repeats
        push_cmd(8'h9F, 0, 0);
        cs_go; tx_byte(8'h9F, d);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] e;
            e = IDW[8*(3 - (i % 4)) +: 8];
            tx_byte(8'h00, d); chk(d == e, "R8 id byte", d, e);
        end
        cs_stop;
        push_cmd(8'hAB, 0, 0);
        cs_go; tx_byte(8'hAB, d); tx_byte(8'h00, d); tx_byte(8'h00, d); tx_byte(8'h00, d);
        tx_byte(8'h00, d); chk(d == SIG, "R8 signature", d, SIG);
        tx_byte(8'h00, d); chk(d == SIG, "R8 signature repeat", d, SIG);
        cs_stop;

        // R9 read ended inside header
        cs_go; tx_byte(8'h03, d); tx_byte(8'h00, d); tx_byte(8'h12, d); cs_stop;
        chk(exp_cmd.size() == 0, "R9 short read no strobe", exp_cmd.size(), 0);

        // R11 unknown opcode
        cs_go; tx_byte(8'h5A, d); tx_byte(8'h00, d);
        chk(sdo_oe == 0, "R11 unknown keeps oe low", sdo_oe, 0);
        cs_stop;

        // R10 busy blocks array and latch commands
        busy = 1'b1;
        r0 = n_rdreq;
        cs_go; tx_byte(8'h03, d); tx_byte(8'h00, d); tx_byte(8'h00, d); tx_byte(8'h20, d); tx_byte(8'h00, d);
        chk(sdo_oe == 0, "R10 busy read oe low", sdo_oe, 0);
        cs_stop;
        chk(n_rdreq == r0, "R10 busy no rd_req", n_rdreq - r0, 0);
        cmd1(8'h06);
        rdsr(8'h01, "R10 busy status, latch unchanged");
        busy = 1'b0;
        rdsr(8'h00, "R7 status after busy");

        // R5 over-long program capped
        push_cmd(8'h06, 0, 0); cmd1(8'h06);
        push_cmd(8'h02, 24'h00AB00, PAGE);
        for (int i = 0; i < PAGE; i++) exp_wr.push_back({i[7:0], i[7:0] ^ 8'h5A});
        cs_go; tx_byte(8'h02, d); tx_byte(8'h00, d); tx_byte(8'hAB, d); tx_byte(8'h00, d);
        for (int i = 0; i < PAGE + 2; i++) tx_byte(i[7:0] ^ 8'h5A, d);
        cs_stop;

        // R5 status write streams one byte
        push_cmd(8'h06, 0, 0); cmd1(8'h06);
        push_cmd(8'h01, 0, 1);
        exp_wr.push_back({8'd0, 8'h9C});
        cs_go; tx_byte(8'h01, d); tx_byte(8'h9C, d); cs_stop;
        rdsr(8'h00, "R4 latch cleared by status write");

        repeat (4) @(negedge clk);
        chk(exp_cmd.size() == 0, "R3 missing strobes", exp_cmd.size(), 0);
        chk(exp_wr.size() == 0, "R5 missing data bytes", exp_wr.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule